// File: doc/BRIEF.md
# Gated Signature Analysis Register

This block compresses a serial bit stream into a 16-bit signature, the classic method for checking a circuit node during board test. Four single-bit probe lines enter the block: a window-open line, a window-close line, a sampling clock line and a data line. All four are asynchronous to the system clock. They pass through two-flop synchronizers, and the block then looks for edges by comparing each synchronized line with its value one system clock earlier.

An active edge on the open line clears the signature register and opens the window. While the window is open, every active edge of the sampling clock line shifts the register one place to the right. The new top bit is the data bit XOR the parity of the register bits that a fixed tap mask selects. An active edge on the close line ends the window. The finished signature then appears on the output with a valid pulse one cycle long, and the output holds that value until the next window closes. Three configuration inputs choose the active polarity of the open, close and sampling lines.

Top module: `sig_analyzer`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, sig_out reads 0, sig_valid reads 0 and the window is closed.
- R2: Each probe input passes through a two-stage synchronizer. An edge is a difference between a synchronized value and its value one system clock earlier. A probe level that is held for 4 system clocks is fully seen by the block.
- R3: On each shift the register moves right by one place. The new bit 15 equals the data bit XOR the parity of the register bits at positions 0, 4, 7 and 9 (mask 0x0291). Starting from zero, a single data 1 gives 0x8000, and a second data 1 then gives 0xC000.
- R4: An active edge on start_in clears the register to 0 and opens the window. If the window is already open, the edge restarts the window from 0 and produces no sig_valid pulse.
- R5: An active edge on stop_in while the window is open closes it. On the next clock edge sig_out takes the register value and sig_valid goes high for exactly one cycle.
- R6: An active edge on stop_in while the window is closed has no effect. Clock-line edges outside the window do not change the register. sig_out holds its value whenever sig_valid is low.
- R7: Polarity control works as follows. cfg_start_fall=0 selects the rising edge of start_in and 1 selects the falling edge. cfg_stop_fall does the same for stop_in. cfg_clk_rise=0 samples on the falling edge of clk_in and 1 samples on the rising edge. Edges of the opposite polarity are ignored.
- R8: When start and stop edges occur in the same cycle with the window open, the current signature is reported with a sig_valid pulse, and a new window opens from 0 in that same cycle.
- R9: A clock-line edge that falls in the same cycle as a start or stop edge does not shift the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_in | input | 1 | Asynchronous window-open probe |
| stop_in | input | 1 | Asynchronous window-close probe |
| clk_in | input | 1 | Asynchronous sampling clock probe |
| data_in | input | 1 | Asynchronous data probe |
| cfg_start_fall | input | 1 | 1 selects the falling edge of start_in |
| cfg_stop_fall | input | 1 | 1 selects the falling edge of stop_in |
| cfg_clk_rise | input | 1 | 1 samples on the rising edge of clk_in |
| sig_out | output | 16 | Signature of the last completed window |
| sig_valid | output | 1 | One-cycle pulse when sig_out updates |

## Verification
Two short known-answer windows (one data 1, then two) pin down the shift direction, the tap mask and the clearing at window open. Random windows of varied length, with random data and random polarity for all three edge lines, compare each reported signature with a bench model. This separates a wrong tap or shift from a wrong polarity decode. Directed cases cover the remaining control paths:
- a close edge with no open window;
- clock edges between windows;
- a restart while a window is open;
- open and close edges together;
- a clock edge that arrives together with the close edge.

Each of these shows whether the gating logic acts on an edge that it should ignore.

// File: rtl/sig_pkg.sv
// Package sig_pkg
// Shared constants for the signature analyser: channel positions on the
// synchronizer bus and the default tap mask.
package sig_pkg;
    localparam int CH_START = 0;
    localparam int CH_STOP  = 1;
    localparam int CH_CLK   = 2;
    localparam int CH_DATA  = 3;
    localparam int NUM_CH   = 4;
    localparam int NUM_EDGE = 3;   // channels that need edge detection

    localparam logic [15:0] DEFAULT_TAPS = 16'h0291;
endpackage

// File: rtl/sig_sync.sv
// Module sig_sync
// Multi-stage synchronizer for a bus of independent single-bit signals.
// Assumes each bit is asynchronous and may be sampled in any cycle; no
// relation between bits is preserved.
module sig_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one register stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= d_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/sig_edge.sv
// Module sig_edge
// Edge detector for one synchronized line with selectable polarity.
// Assumes the input is already in the clk domain. Edges are reported only
// while 'arm' is high, so that the reset-to-level transition is not seen.
module sig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic level,
    input  logic fall_sel,
    output logic ev
);
    logic prev_q;

    // Purpose: remember the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Purpose: flag an edge of the selected polarity.
    always_comb begin
        if (fall_sel) ev = arm & prev_q & ~level;
        else          ev = arm & ~prev_q & level;
    end
endmodule

// File: rtl/sig_lfsr.sv
// Module sig_lfsr
// Right-shifting signature register. The new top bit is the data bit XOR
// the parity of the tapped register bits. A synchronous clear has priority
// over a shift.
module sig_lfsr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] TAPS = 16'h0291
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] state
);
    logic         fb;
    logic [W-1:0] state_q;

    // Purpose: feedback bit = data XOR parity of tapped bits.
    always_comb fb = din ^ (^(state_q & TAPS));

    // Purpose: clear or shift the signature register.
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= '0;
        else if (clr)   state_q <= '0;
        else if (shift) state_q <= {fb, state_q[W-1:1]};
    end

    assign state = state_q;
endmodule

// File: rtl/sig_analyzer.sv
// Module sig_analyzer
// Gated signature analyser. It synchronizes four probe lines, finds the
// start/stop/clock edges with selectable polarity, and compresses the data
// line into a signature between a start edge and a stop edge.
// Assumes every probe level lasts at least STAGES+1 system clocks.
module sig_analyzer #(
    parameter int                SIG_W  = 16,
    parameter logic [SIG_W-1:0]  TAPS   = sig_pkg::DEFAULT_TAPS,
    parameter int                STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_in,
    input  logic             stop_in,
    input  logic             clk_in,
    input  logic             data_in,
    input  logic             cfg_start_fall,
    input  logic             cfg_stop_fall,
    input  logic             cfg_clk_rise,
    output logic [SIG_W-1:0] sig_out,
    output logic             sig_valid
);
    import sig_pkg::*;

    localparam int ARM_CNT = STAGES + 1;
    localparam int ARM_W   = $clog2(ARM_CNT + 1);

    logic [NUM_CH-1:0]   raw_in;
    logic [NUM_CH-1:0]   sync_lvl;
    logic [NUM_EDGE-1:0] pol_fall;
    logic [NUM_EDGE-1:0] edge_ev;
    logic [ARM_W-1:0]    arm_cnt_q;
    logic                armed;
    logic                start_ev, stop_ev, clk_ev;
    logic                gate_q;
    logic                do_shift;
    logic [SIG_W-1:0]    sig_q;
    logic [SIG_W-1:0]    sig_out_q;
    logic                sig_valid_q;

    // Purpose: collect the probe lines onto one bus.
    always_comb begin
        raw_in           = '0;
        raw_in[CH_START] = start_in;
        raw_in[CH_STOP]  = stop_in;
        raw_in[CH_CLK]   = clk_in;
        raw_in[CH_DATA]  = data_in;
    end

    sig_sync #(.WIDTH(NUM_CH), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_lvl)
    );

    // Purpose: hold edge detection off until the synchronizers are filled.
    always_ff @(posedge clk) begin
        if (!rst_n)                            arm_cnt_q <= '0;
        else if (arm_cnt_q != ARM_W'(ARM_CNT)) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
    assign armed = (arm_cnt_q == ARM_W'(ARM_CNT));

    // Purpose: per-channel polarity select (1 = falling edge active).
    always_comb begin
        pol_fall           = '0;
        pol_fall[CH_START] = cfg_start_fall;
        pol_fall[CH_STOP]  = cfg_stop_fall;
        pol_fall[CH_CLK]   = ~cfg_clk_rise;
    end

    generate
        for (genvar c = 0; c < NUM_EDGE; c++) begin : g_edge
            sig_edge u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .arm      (armed),
                .level    (sync_lvl[c]),
                .fall_sel (pol_fall[c]),
                .ev       (edge_ev[c])
            );
        end
    endgenerate

    assign start_ev = edge_ev[CH_START];
    assign stop_ev  = edge_ev[CH_STOP];
    assign clk_ev   = edge_ev[CH_CLK];

    // Purpose: open/close the measurement window; start wins for reopening.
    always_ff @(posedge clk) begin
        if (!rst_n)        gate_q <= 1'b0;
        else if (start_ev) gate_q <= 1'b1;
        else if (stop_ev)  gate_q <= 1'b0;
    end

    // Purpose: shift only on a lone clock edge inside the window.
    assign do_shift = gate_q & clk_ev & ~start_ev & ~stop_ev;

    sig_lfsr #(.W(SIG_W), .TAPS(TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ev),
        .shift (do_shift),
        .din   (sync_lvl[CH_DATA]),
        .state (sig_q)
    );

    // Purpose: latch the finished signature and pulse valid on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_out_q   <= '0;
            sig_valid_q <= 1'b0;
        end else begin
            sig_valid_q <= 1'b0;
            if (stop_ev && gate_q) begin
                sig_out_q   <= sig_q;
                sig_valid_q <= 1'b1;
            end
        end
    end

    assign sig_out   = sig_out_q;
    assign sig_valid = sig_valid_q;
endmodule

// File: rtl/sig_analyzer_chk.sv
// Module sig_analyzer_chk
// Property checker for sig_analyzer, attached through bind. It watches
// the window state, the register and the edge events.
module sig_analyzer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         gate_q,
    input logic         start_ev,
    input logic         stop_ev,
    input logic         clk_ev,
    input logic [W-1:0] sig_q,
    input logic [W-1:0] sig_out,
    input logic         sig_valid
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |=> !sig_valid);                                  // R5
    AST_VALID_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !gate_q && !start_ev) |=> !sig_valid);          // R6
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_valid |=> (sig_valid || $stable(sig_out)));            // R6
    AST_CLEAR_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (sig_q == '0 && gate_q));                      // R4
    AST_FROZEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q && !start_ev) |=> $stable(sig_q));                 // R6
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && clk_ev && !start_ev && !stop_ev)
        |=> sig_q[W-2:0] == $past(sig_q[W-1:1]));                   // R3
    AST_NO_SHIFT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && stop_ev && !start_ev) |=> $stable(sig_q));       // R9
    AST_REOPEN_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && start_ev && stop_ev) |=> (sig_valid && gate_q)); // R8
endmodule

bind sig_analyzer sig_analyzer_chk #(.W(SIG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_q    (gate_q),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .clk_ev    (clk_ev),
    .sig_q     (sig_q),
    .sig_out   (sig_out),
    .sig_valid (sig_valid)
);

// File: tb/test_sig_analyzer.sv
// Bench for sig_analyzer: directed corner cases plus seeded random windows,
// compared with a bench model of the signature.
module test_sig_analyzer;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_in = 1'b0, stop_in = 1'b0, clk_in = 1'b0, data_in = 1'b0;
    logic        cfg_start_fall = 1'b0, cfg_stop_fall = 1'b0, cfg_clk_rise = 1'b0;
    logic [15:0] sig_out;
    logic        sig_valid;

    int          n_vec = 0;
    int          n_bad = 0;
    int          n_pulse = 0;
    logic [15:0] last_sig = '0;
    bit          finished = 1'b0;

    // bench model state
    bit          m_open = 1'b0;
    logic [15:0] m_sig = '0;

    sig_analyzer i_sig_analyzer (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .stop_in(stop_in),
        .clk_in(clk_in), .data_in(data_in), .cfg_start_fall(cfg_start_fall),
        .cfg_stop_fall(cfg_stop_fall), .cfg_clk_rise(cfg_clk_rise),
        .sig_out(sig_out), .sig_valid(sig_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && sig_valid) begin
            n_pulse  <= n_pulse + 1;
            last_sig <= sig_out;
        end
    end

    function automatic logic [15:0] model_next(logic [15:0] s, logic d);
        return {d ^ (^(s & 16'h0291)), s[15:1]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (HOLD) @(negedge clk);
    endtask

    // Active-level targets: rising -> line ends high, falling -> ends low.
    task automatic start_edge();
        start_in = cfg_start_fall; settle();
        start_in = ~cfg_start_fall; settle();
    endtask

    task automatic stop_edge();
        stop_in = cfg_stop_fall; settle();
        stop_in = ~cfg_stop_fall; settle();
    endtask

    task automatic clk_edge(logic d);
        data_in = d; clk_in = ~cfg_clk_rise; settle();
        clk_in = cfg_clk_rise; settle();
    endtask

    // Model-updating wrappers that also check the reported pulse.
    task automatic do_start(string req);
        int p0;
        p0 = n_pulse;
        start_edge();
        check(req, n_pulse - p0, 0);
        m_open = 1'b1; m_sig = '0;
    endtask

    task automatic do_clk(logic d);
        clk_edge(d);
        if (m_open) m_sig = model_next(m_sig, d);
    endtask

    task automatic do_stop(string req);
        int p0;
        p0 = n_pulse;
        stop_edge();
        if (m_open) begin
            check(req, n_pulse - p0, 1);
            check(req, last_sig, m_sig);
            check(req, sig_out, m_sig);
        end else begin
            check(req, n_pulse - p0, 0);
        end
        m_open = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int p0;
        logic [15:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 sig_out in reset", sig_out, 0);
        check("R1 sig_valid in reset", sig_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sig_out after release", sig_out, 0);
        check("R1 sig_valid after release", sig_valid, 0);
        settle();

        // R3 known answers
        do_start("R4 open");
        do_clk(1'b1);
        do_stop("R3 one bit");
        check("R3 literal 0x8000", sig_out, 16'h8000);
        do_start("R4 open");
        do_clk(1'b1); do_clk(1'b1);
        do_stop("R3 two bits");
        check("R3 literal 0xC000", sig_out, 16'hC000);

        // R6: stop while closed, clocks outside window, output held
        held = sig_out;
        do_stop("R6 stop while closed");
        for (int i = 0; i < 5; i++) do_clk(1'b1);
        check("R6 held after idle clocks", sig_out, held);
        do_start("R6 open after idle clocks");
        do_clk(1'b0);
        do_stop("R6 idle clocks left no trace");

        // R4: restart while open
        do_start("R4 open");
        for (int i = 0; i < 7; i++) do_clk(1'b1);
        do_start("R4 restart gives no pulse");
        do_clk(1'b1);
        do_stop("R4 restart cleared register");
        check("R4 restart literal", sig_out, 16'h8000);

        // R8: start and stop together
        do_start("R8 open");
        do_clk(1'b1); do_clk(1'b0); do_clk(1'b1);
        p0 = n_pulse;
        start_in = cfg_start_fall; stop_in = cfg_stop_fall; settle();
        start_in = ~cfg_start_fall; stop_in = ~cfg_stop_fall; settle();
        check("R8 pulse count", n_pulse - p0, 1);
        check("R8 reported signature", last_sig, m_sig);
        m_sig = '0; m_open = 1'b1;
        do_clk(1'b1);
        do_stop("R8 new window from zero");
        check("R8 literal", sig_out, 16'h8000);

        // R9: clock edge together with stop edge
        do_start("R9 open");
        do_clk(1'b1);
        data_in = 1'b1; clk_in = ~cfg_clk_rise; stop_in = cfg_stop_fall; settle();
        p0 = n_pulse;
        clk_in = cfg_clk_rise; stop_in = ~cfg_stop_fall; settle();
        check("R9 pulse", n_pulse - p0, 1);
        check("R9 coinciding clock not shifted", last_sig, 16'h8000);
        m_open = 1'b0;

        // R7: inverted polarities, directed
        cfg_start_fall = 1'b1; cfg_stop_fall = 1'b1; cfg_clk_rise = 1'b1;
        settle();
        do_start("R7 falling start");
        do_clk(1'b1); do_clk(1'b0); do_clk(1'b1);
        do_stop("R7 falling stop rising clock");

        // R2/R3/R7 random windows
        for (int w = 0; w < 60; w++) begin
            int len;
            cfg_start_fall = 1'($urandom_range(0, 1));
            cfg_stop_fall  = 1'($urandom_range(0, 1));
            cfg_clk_rise   = 1'($urandom_range(0, 1));
            settle();
            if ($urandom_range(0, 7) == 0) do_stop("R6 random stray stop");
            do_start("R4 random open");
            len = $urandom_range(0, 30);
            for (int b = 0; b < len; b++) begin
                do_clk(1'($urandom_range(0, 1)));
                if ($urandom_range(0, 40) == 0) do_start("R4 random restart");
            end
            do_stop("R3 R7 random window");
            if ($urandom_range(0, 3) == 0) begin
                held = sig_out;
                do_clk(1'($urandom_range(0, 1)));
                check("R6 random held", sig_out, held);
            end
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule